// File: doc/BRIEF.md
# Alternating Bit Link

This block is a matched transmitter and receiver pair that moves data words across a channel that can lose traffic. At any time at most one word is in flight, and a single sequence bit tells a new word from a repeated one. The transmitter takes a word on a valid/ready input. It sends the word tagged with its current sequence bit, and it keeps sending it again until an acknowledgement with the same bit comes back. The receiver passes each new word to its output exactly once and answers every message with an acknowledgement.

The channel itself is not part of the block. The transmitter's message port and the receiver's acknowledgement port are brought out as separate inputs and outputs. The surrounding logic, or a test model, joins them through whatever lossy medium is present. Each message and each acknowledgement is a pulse that lasts one clock cycle.

Top module: `abp_link`

## Requirements
- R1: After reset both sequence bits are 0, `in_ready_o` is high, and `tx_valid_o`, `out_valid_o` and `ack_tx_valid_o` are low.
- R2: A word is accepted only while `in_ready_o` is high. In the cycle after acceptance, `tx_valid_o` pulses for one cycle carrying that word and the current sequence bit, and `in_ready_o` stays low until the word is acknowledged.
- R3: An acknowledgement whose bit equals the transmitter's bit, arriving while the transmitter waits, inverts that bit and raises `in_ready_o` in the next cycle. The next word is then sent with the inverted bit.
- R4: An acknowledgement with the other bit, arriving while the transmitter waits, causes a resend of the same word with the same bit in the next cycle.
- R5: If no acknowledgement arrives, the same word and bit are sent again TIMEOUT+1 cycles after the previous send. The wait timer restarts on every send.
- R6: A message whose bit equals the receiver's expected bit is delivered on `out_valid_o`/`out_data_o` one cycle later. In the same cycle an acknowledgement carrying that bit is sent, and the expected bit inverts.
- R7: A message with the other bit is not delivered. It is answered one cycle later by an acknowledgement carrying the inverse of the expected bit, which is the bit of the message.
- R8: After RX_TIMEOUT cycles with no message, the receiver sends an acknowledgement carrying the inverse of its expected bit, with no delivery.
- R9: Through a channel that drops messages and acknowledgements, the delivered words equal the accepted words, in order, with none repeated. Once losses stop, every accepted word is delivered.
- R10: An acknowledgement arriving while the transmitter is idle has no effect on the bit used for the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Source word valid |
| in_data_i | input | DATA_W | Source word |
| in_ready_o | output | 1 | Transmitter idle, can take a word |
| tx_valid_o | output | 1 | Message pulse toward the channel |
| tx_data_o | output | DATA_W | Message word |
| tx_mode_o | output | 1 | Message sequence bit |
| rx_valid_i | input | 1 | Message pulse from the channel |
| rx_data_i | input | DATA_W | Received word |
| rx_mode_i | input | 1 | Received sequence bit |
| ack_tx_valid_o | output | 1 | Acknowledgement pulse toward the channel |
| ack_tx_mode_o | output | 1 | Acknowledgement bit sent |
| ack_rx_valid_i | input | 1 | Acknowledgement pulse from the channel |
| ack_rx_mode_i | input | 1 | Acknowledgement bit received |
| out_valid_o | output | 1 | Delivered word valid, one cycle |
| out_data_o | output | DATA_W | Delivered word |

## Verification
The hardest case to reach is a lost acknowledgement after a successful delivery. In that case the receiver has already inverted its bit, so the resend reaches it with the wrong bit. It must be discarded, yet answered in a way that lets the transmitter advance. The stimulus table gives each word its own count of messages and acknowledgements to drop, so this case and its chained variants occur at fixed points. A random-loss phase then mixes the same cases with both timers expiring.

// File: rtl/abp_pkg.sv
package abp_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SEND = 2'd1,
    S_WAIT = 2'd2
  } snd_state_e;
endpackage

// File: rtl/abp_timer.sv
module abp_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !clear_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i || expire_o) cnt_q <= '0;
    else if (run_i)               cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT)); // R5
endmodule

// File: rtl/abp_sender.sv
module abp_sender
  import abp_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned TIMEOUT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_mode_o,
  input  logic              ack_valid_i,
  input  logic              ack_mode_i
);
  snd_state_e        state_q, state_d;
  logic              mode_q;
  logic [DATA_W-1:0] data_q;
  logic              ack_hit, ack_miss, tmr_expire;

  assign in_ready_o = (state_q == S_IDLE);
  assign tx_valid_o = (state_q == S_SEND);
  assign tx_data_o  = data_q;
  assign tx_mode_o  = mode_q;

  assign ack_hit  = (state_q == S_WAIT) && ack_valid_i && (ack_mode_i == mode_q);
  assign ack_miss = (state_q == S_WAIT) && ack_valid_i && (ack_mode_i != mode_q);

  abp_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (state_q == S_SEND),
    .run_i    (state_q == S_WAIT),
    .expire_o (tmr_expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (in_valid_i) state_d = S_SEND;
      S_SEND:  state_d = S_WAIT;
      S_WAIT: begin
        // acknowledgement wins over a coincident timeout
        if (ack_hit)                     state_d = S_IDLE;
        else if (ack_miss || tmr_expire) state_d = S_SEND;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (ack_hit) mode_q <= ~mode_q;
      if (state_q == S_IDLE && in_valid_i) data_q <= in_data_i;
    end
  end

  AST_SEND_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_valid_o && !in_ready_o); // R2
  AST_HIT_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hit |=> in_ready_o && (tx_mode_o != $past(tx_mode_o))); // R3
  AST_MISS_RESEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_miss |=> tx_valid_o && $stable(tx_mode_o) && $stable(tx_data_o)); // R4
  AST_TIMEOUT_RESEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_expire |=> tx_valid_o && $stable(tx_mode_o) && $stable(tx_data_o)); // R5
  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && ack_valid_i) |=> $stable(tx_mode_o)); // R10
endmodule

// File: rtl/abp_receiver.sv
module abp_receiver #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RX_TIMEOUT = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_mode_i,
  output logic              ack_valid_o,
  output logic              ack_mode_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic              exp_q;
  logic              ack_valid_q, ack_mode_q, out_valid_q;
  logic [DATA_W-1:0] out_data_q;
  logic              good, bad, tmr_expire;

  assign good = rx_valid_i && (rx_mode_i == exp_q);
  assign bad  = rx_valid_i && (rx_mode_i != exp_q);

  abp_timer #(.LIMIT(RX_TIMEOUT)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (rx_valid_i),
    .run_i    (1'b1),
    .expire_o (tmr_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q       <= 1'b0;
      ack_valid_q <= 1'b0;
      ack_mode_q  <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= good;
      ack_valid_q <= rx_valid_i || tmr_expire;
      // error acknowledgement carries the inverse of the expected bit
      ack_mode_q  <= good ? exp_q : ~exp_q;
      if (good) begin
        out_data_q <= rx_data_i;
        exp_q      <= ~exp_q;
      end
    end
  end

  assign ack_valid_o = ack_valid_q;
  assign ack_mode_o  = ack_mode_q;
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;

  AST_GOOD_DELIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good |=> out_valid_o && ack_valid_o && (ack_mode_o == $past(rx_mode_i))); // R6
  AST_DELIVER_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ack_valid_o && (ack_mode_o != exp_q)); // R6
  AST_BAD_NO_DELIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> !out_valid_o && ack_valid_o && (ack_mode_o == $past(rx_mode_i))); // R7
  AST_RX_TIMEOUT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_expire |=> ack_valid_o && !out_valid_o && (ack_mode_o != exp_q)); // R8
endmodule

// File: rtl/abp_link.sv
module abp_link #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned TIMEOUT    = 16,
  parameter int unsigned RX_TIMEOUT = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_mode_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_mode_i,
  output logic              ack_tx_valid_o,
  output logic              ack_tx_mode_o,
  input  logic              ack_rx_valid_i,
  input  logic              ack_rx_mode_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  abp_sender #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_snd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .tx_mode_o   (tx_mode_o),
    .ack_valid_i (ack_rx_valid_i),
    .ack_mode_i  (ack_rx_mode_i)
  );

  abp_receiver #(.DATA_W(DATA_W), .RX_TIMEOUT(RX_TIMEOUT)) u_rcv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .rx_mode_i   (rx_mode_i),
    .ack_valid_o (ack_tx_valid_o),
    .ack_mode_o  (ack_tx_mode_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> in_ready_o && !tx_valid_o && !out_valid_o); // R1
endmodule

// File: tb/tb_abp_link.sv
module tb_abp_link;
  localparam int DW = 8;
  localparam int TO = 16;
  localparam int RTO = 40;
  localparam int NTAB = 8;
  localparam int WD_CYCLES = 150000;

  // {word, messages to drop, acknowledgements to drop}
  localparam logic [DW+7:0] TAB [NTAB] = '{
    {8'h11, 4'd0, 4'd0}, {8'h22, 4'd1, 4'd0}, {8'h33, 4'd0, 4'd1},
    {8'h44, 4'd2, 4'd2}, {8'h55, 4'd0, 4'd3}, {8'h66, 4'd3, 4'd0},
    {8'h77, 4'd1, 4'd1}, {8'h88, 4'd0, 4'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic in_valid = 1'b0; logic [DW-1:0] in_data = '0;
  logic in_ready, tx_valid, tx_mode, ack_tx_valid, ack_tx_mode, out_valid;
  logic [DW-1:0] tx_data, out_data;

  logic link_on = 1'b0;
  logic d_rx_valid = 1'b0, d_rx_mode = 1'b0, d_ack_valid = 1'b0, d_ack_mode = 1'b0;
  logic [DW-1:0] d_rx_data = '0;
  logic c_rx_valid = 1'b0, c_rx_mode = 1'b0, c_ack_valid = 1'b0, c_ack_mode = 1'b0;
  logic [DW-1:0] c_rx_data = '0;
  int drop_msg = 0, drop_ack = 0, loss_pct = 0;

  abp_link #(.DATA_W(DW), .TIMEOUT(TO), .RX_TIMEOUT(RTO)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_mode_o(tx_mode),
    .rx_valid_i(link_on ? c_rx_valid : d_rx_valid),
    .rx_data_i(link_on ? c_rx_data : d_rx_data),
    .rx_mode_i(link_on ? c_rx_mode : d_rx_mode),
    .ack_tx_valid_o(ack_tx_valid), .ack_tx_mode_o(ack_tx_mode),
    .ack_rx_valid_i(link_on ? c_ack_valid : d_ack_valid),
    .ack_rx_mode_i(link_on ? c_ack_mode : d_ack_mode),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  // lossy channel, updated mid-cycle
  always @(negedge clk) begin
    c_rx_valid  <= 1'b0;
    c_ack_valid <= 1'b0;
    if (tx_valid) begin
      if (drop_msg > 0) drop_msg <= drop_msg - 1;
      else if (($urandom % 100) >= loss_pct) begin
        c_rx_valid <= 1'b1; c_rx_data <= tx_data; c_rx_mode <= tx_mode;
      end
    end
    if (ack_tx_valid) begin
      if (drop_ack > 0) drop_ack <= drop_ack - 1;
      else if (($urandom % 100) >= loss_pct) begin
        c_ack_valid <= 1'b1; c_ack_mode <= ack_tx_mode;
      end
    end
  end

  // scoreboard for the end-to-end phases
  logic [DW-1:0] sent [256];
  int wr_idx = 0, rd_idx = 0, sb_checks = 0, sb_errs = 0;
  always @(negedge clk) begin
    if (link_on && out_valid) begin
      sb_checks <= sb_checks + 1;
      if (rd_idx >= wr_idx) begin
        sb_errs <= sb_errs + 1;
        $display("FAIL R9 extra delivery: got %h expected none", out_data);
      end else if (out_data !== sent[rd_idx]) begin
        sb_errs <= sb_errs + 1;
        $display("FAIL R9 order: got %h expected %h", out_data, sent[rd_idx]);
      end
      rd_idx <= rd_idx + 1;
    end
  end

  int checks = 0, errs = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    link_on = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] w);
    while (!in_ready) step();
    in_valid = 1'b1; in_data = w;
    if (link_on) begin sent[wr_idx] = w; wr_idx++; end
    step();
    in_valid = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs + sb_errs, checks + sb_checks);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

  initial begin
    int n;
    do_reset();
    // R1
    chk("R1 in_ready", in_ready, 1); chk("R1 tx_valid", tx_valid, 0);
    chk("R1 out_valid", out_valid, 0); chk("R1 ack_valid", ack_tx_valid, 0);
    chk("R1 tx_mode", tx_mode, 0);

    // R10: stray acknowledgement while idle
    d_ack_valid = 1'b1; d_ack_mode = 1'b0; step(); d_ack_valid = 1'b0;
    push(8'hA5);
    chk("R2 tx_valid", tx_valid, 1); chk("R2 data", tx_data, 8'hA5);
    chk("R10 mode after idle ack", tx_mode, 0); chk("R2 busy", in_ready, 0);
    step();
    chk("R2 single pulse", tx_valid, 0);
    // R4: mismatched acknowledgement
    d_ack_valid = 1'b1; d_ack_mode = 1'b1; step(); d_ack_valid = 1'b0;
    chk("R4 resend", tx_valid, 1); chk("R4 data", tx_data, 8'hA5); chk("R4 mode", tx_mode, 0);
    // R5: timeout period
    n = 0;
    do begin step(); n++; end while (!tx_valid && n < 100);
    chk("R5 period", n, TO + 1); chk("R5 data", tx_data, 8'hA5);
    n = 0;
    do begin step(); n++; end while (!tx_valid && n < 100);
    chk("R5 restart", n, TO + 1);
    // R3: matching acknowledgement
    step();
    d_ack_valid = 1'b1; d_ack_mode = 1'b0; step(); d_ack_valid = 1'b0;
    chk("R3 ready", in_ready, 1);
    push(8'h5A);
    chk("R3 new mode", tx_mode, 1); chk("R3 data", tx_data, 8'h5A);

    // receiver directed
    do_reset();
    d_rx_valid = 1'b1; d_rx_mode = 1'b0; d_rx_data = 8'hC3; step(); d_rx_valid = 1'b0;
    chk("R6 deliver", out_valid, 1); chk("R6 data", out_data, 8'hC3);
    chk("R6 ack", ack_tx_valid, 1); chk("R6 ack mode", ack_tx_mode, 0);
    step();
    chk("R6 once", out_valid, 0);
    d_rx_valid = 1'b1; d_rx_mode = 1'b0; d_rx_data = 8'hC3; step(); d_rx_valid = 1'b0;
    chk("R7 no deliver", out_valid, 0); chk("R7 ack", ack_tx_valid, 1);
    chk("R7 ack mode", ack_tx_mode, 0);
    d_rx_valid = 1'b1; d_rx_mode = 1'b1; d_rx_data = 8'h3C; step(); d_rx_valid = 1'b0;
    chk("R6 second", out_valid, 1); chk("R6 data2", out_data, 8'h3C);
    chk("R6 ack mode2", ack_tx_mode, 1);
    n = 0;
    do begin step(); n++; end while (!ack_tx_valid && n < 200);
    chk("R8 period", n, RTO); chk("R8 mode", ack_tx_mode, 1); chk("R8 no deliver", out_valid, 0);

    // R9: table of loss patterns
    do_reset(); link_on = 1'b1;
    for (int i = 0; i < NTAB; i++) begin
      drop_msg = int'(TAB[i][7:4]); drop_ack = int'(TAB[i][3:0]);
      push(TAB[i][DW+7:8]);
      n = 0;
      while (!in_ready && n < 2000) begin step(); n++; end
      chk("R9 table delivered", rd_idx, i + 1);
    end
    // R9: random losses, then a clean tail
    loss_pct = 35;
    for (int i = 0; i < 40; i++) push(DW'($urandom));
    loss_pct = 0;
    for (int i = 0; i < 8; i++) push(DW'(i * 29 + 7));
    n = 0;
    while (rd_idx < wr_idx && n < 5000) begin step(); n++; end
    repeat (2 * RTO) step();
    chk("R9 all delivered", rd_idx, wr_idx);
    report();
    $finish;
  end
endmodule